// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Bus Slave

This block lets an external host reach a small bank of byte-wide registers over an asynchronous parallel bus. The host picks the bus flavour with a style input. One flavour has separate active-low read and write strobes. The other has one active-low data strobe plus a direction line that is high for a read and low for a write. A second input chooses how the address arrives: either on its own address pins, or time-shared on the low bits of the data pins ahead of a latch pulse.

Every host line goes through the same two-flop synchronizer into the system clock. Address pins and data pins go through it too, so each bus snapshot stays aligned with the strobe levels that travel with it. All edges are found in the system clock domain. An active-low completion output stays high while the host has to wait. It goes low a fixed number of clocks after the strobe is seen, and returns high once the strobe has gone away.

Top module: `hbus_slave`

## Requirements
- R1: After synchronous reset, `done_n` is 1, `data_oe` is 0, and every register reads back as 0x00.
- R2: With `bus_style`=0 and `addr_muxed`=1, the address is taken from `data_in[5:0]` when `latch_in` goes from 1 to 0. `addr_in` has no effect.
- R3: With `bus_style`=0 and `addr_muxed`=0, the address is taken from `addr_in` when either `rd_dir_in` or `wr_ds_in` first goes low.
- R4: With `bus_style`=0, a register write happens when `wr_ds_in` returns high. It stores the last `data_in` value seen while `wr_ds_in` was low.
- R5: With `bus_style`=1 and `addr_muxed`=1, the address is taken from `data_in[5:0]` when `latch_in` falls.
- R6: With `bus_style`=1 and `addr_muxed`=0, the address is taken from `addr_in` when `wr_ds_in` falls.
- R7: With `bus_style`=1, `rd_dir_in` is sampled when `wr_ds_in` falls. If it is 0, the cycle writes the last `data_in` seen while `wr_ds_in` was low, and the write happens when `wr_ds_in` rises. If it is 1, the cycle reads and no register changes.
- R8: `data_out` shows the register at the latched address. `data_oe` is 1 only while a read strobe is active: `rd_dir_in`=0 when `bus_style`=0, or `wr_ds_in`=0 with `rd_dir_in`=1 when `bus_style`=1.
- R9: `done_n` goes low exactly 4 clock edges after the strobe is asserted (2 synchronizer stages plus 2 wait clocks). It is never low outside an active cycle.
- R10: `done_n` returns high on the third clock edge after the strobe is released. A strobe released before the wait expires gives no low pulse on `done_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_style | input | 1 | 0: separate read/write strobes; 1: data strobe with direction line |
| addr_muxed | input | 1 | 1: address time-shared on data pins; 0: dedicated address pins |
| latch_in | input | 1 | Address latch pulse, falling edge captures (multiplexed only; tie high otherwise) |
| rd_dir_in | input | 1 | Read strobe, active low (style 0), or direction, 1 = read (style 1) |
| wr_ds_in | input | 1 | Write strobe (style 0) or data strobe (style 1), active low |
| addr_in | input | 6 | Dedicated address pins |
| data_in | input | 8 | Data pins inbound; carry the address in multiplexed mode |
| data_out | output | 8 | Read data for the latched address |
| data_oe | output | 1 | Pad drive enable for read data |
| done_n | output | 1 | Cycle-complete handshake, low = done, high = wait |

## Verification
The hardest case to reach from the ports is the start-of-cycle handshake window. It lies between the third and fourth clock after a strobe falls, and `done_n` must flip there and nowhere else. The bench drives every strobe on the falling clock edge and samples `done_n` on each following falling edge. That pins the exact cycle in all four style/address combinations, over every one of the 64 addresses. A single-clock strobe pulse checks that an early release suppresses the completion pulse. Read cycles put deliberate garbage on the unused bus pins, so a stray write or a wrongly sourced address shows up as a mismatch in a later read-back.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int ADDR_W_DEF      = 6;
    localparam int DATA_W_DEF      = 8;
    localparam int SYNC_STAGES_DEF = 2;
    localparam int WAIT_CYC_DEF    = 2;

    typedef enum logic {
        BUS_SEP_RW = 1'b0,   // separate active-low read and write strobes
        BUS_DS_DIR = 1'b1    // one data strobe plus a direction line
    } bus_style_e;

    typedef struct packed {
        logic latch;         // address latch pulse
        logic rd_dir;        // read strobe (style 0) or direction, 1 = read (style 1)
        logic wr_ds;         // write strobe (style 0) or data strobe (style 1)
    } ctl_lines_t;

    localparam int CTL_W = $bits(ctl_lines_t);

    typedef struct packed {
        logic strobe_act;
        logic cyc_start;
        logic cyc_end;
        logic addr_latch;
        logic addr_from_data;
        logic wr_commit;
        logic read_act;
    } bus_evt_t;

    function automatic logic strobe_active(bus_style_e st, ctl_lines_t l);
        if (st == BUS_SEP_RW)
            return !l.rd_dir || !l.wr_ds;
        return !l.wr_ds;
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    logic [STAGES-1:0][W-1:0] stage_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++)
                stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign cur  = stage_q[STAGES-1];
    assign prev = prev_q;

endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
(
    input  bus_style_e style,
    input  logic       muxed,
    input  ctl_lines_t cur,
    input  ctl_lines_t prev,
    input  logic       dir_read,
    output bus_evt_t   evt
);

    logic st_cur;
    logic st_prev;

    always_comb begin
        st_cur  = strobe_active(style, cur);
        st_prev = strobe_active(style, prev);

        evt                = '0;
        evt.strobe_act     = st_cur;
        evt.cyc_start      = st_cur && !st_prev;
        evt.cyc_end        = !st_cur && st_prev;
        evt.addr_from_data = muxed;
        // multiplexed: latch pulse falling; dedicated pins: cycle start
        evt.addr_latch     = muxed ? (prev.latch && !cur.latch) : evt.cyc_start;

        if (style == BUS_SEP_RW) begin
            evt.wr_commit = !prev.wr_ds && cur.wr_ds;
            evt.read_act  = !cur.rd_dir;
        end else begin
            evt.wr_commit = evt.cyc_end && !dir_read;
            evt.read_act  = !cur.wr_ds && cur.rd_dir;
        end
    end

endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr_en && wr_addr == AW'(g))
                word_q <= wr_data;
        end
        assign words[g] = word_q;
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int WAIT_CYC    = WAIT_CYC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_style,
    input  logic              addr_muxed,
    input  logic              latch_in,
    input  logic              rd_dir_in,
    input  logic              wr_ds_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              done_n
);

    localparam int SNAP_W = CTL_W + ADDR_W + DATA_W;
    localparam int CNT_W  = $clog2(WAIT_CYC + 1);
    localparam logic [SNAP_W-1:0] SNAP_RST = {{CTL_W{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

    bus_style_e        style;
    logic [SNAP_W-1:0] snap_cur;
    logic [SNAP_W-1:0] snap_prev;
    ctl_lines_t        ctl_cur;
    ctl_lines_t        ctl_prev;
    logic [ADDR_W-1:0] addr_cur;
    logic [DATA_W-1:0] data_cur;
    logic [DATA_W-1:0] data_prev;
    bus_evt_t          evt;

    logic [ADDR_W-1:0] addr_q;
    logic              dir_read_q;
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              strobe_act;
    logic              wr_commit;

    assign style = bus_style_e'(bus_style);

    // strobes and bus pins share one synchronizer so snapshots stay aligned
    hbus_sync #(
        .W       (SNAP_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SNAP_RST)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    ({latch_in, rd_dir_in, wr_ds_in, addr_in, data_in}),
        .cur  (snap_cur),
        .prev (snap_prev)
    );

    assign ctl_cur   = ctl_lines_t'(snap_cur[SNAP_W-1 -: CTL_W]);
    assign ctl_prev  = ctl_lines_t'(snap_prev[SNAP_W-1 -: CTL_W]);
    assign addr_cur  = snap_cur[DATA_W +: ADDR_W];
    assign data_cur  = snap_cur[0 +: DATA_W];
    assign data_prev = snap_prev[0 +: DATA_W];

    hbus_decode u_dec (
        .style    (style),
        .muxed    (addr_muxed),
        .cur      (ctl_cur),
        .prev     (ctl_prev),
        .dir_read (dir_read_q),
        .evt      (evt)
    );

    assign strobe_act = evt.strobe_act;
    assign wr_commit  = evt.wr_commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            dir_read_q <= 1'b1;
            busy_q     <= 1'b0;
            cnt_q      <= '0;
        end else begin
            if (evt.addr_latch)
                addr_q <= evt.addr_from_data ? data_cur[ADDR_W-1:0] : addr_cur;
            if (evt.cyc_start)
                dir_read_q <= ctl_cur.rd_dir;
            if (evt.cyc_start) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(WAIT_CYC - 1);
            end else if (evt.cyc_end) begin
                busy_q <= 1'b0;
            end else if (busy_q && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // write data is the last snapshot taken while the strobe was still active
    hbus_regfile #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_commit),
        .wr_addr (addr_q),
        .wr_data (data_prev),
        .rd_addr (addr_q),
        .rd_data (data_out)
    );

    assign data_oe = evt.read_act;
    assign done_n  = !(busy_q && cnt_q == '0);

endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk #(
    parameter int WAIT_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic done_n,
    input logic data_oe,
    input logic busy,
    input logic strobe_act,
    input logic wr_commit
);

    // R1: reset leaves the handshake idle
    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (done_n && !busy));

    // R9: completion only inside an active cycle
    a_r9_ack_inside_cycle: assert property (@(posedge clk) disable iff (rst)
        !done_n |-> busy);

    // R9: no completion on the first busy clock when a wait is configured
    a_r9_no_early_ack: assert property (@(posedge clk) disable iff (rst)
        ((WAIT_CYC > 1) && $rose(busy)) |-> done_n);

    // R10: strobe gone means done_n released on the next clock
    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        (busy && !strobe_act) |=> done_n);

    // R4: register writes only happen within a tracked cycle
    a_r4_commit_in_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> busy);

    // R8: read drive and a register write never coincide
    a_r8_no_oe_on_write: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !wr_commit);

endmodule

bind hbus_slave hbus_slave_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .done_n     (done_n),
    .data_oe    (data_oe),
    .busy       (busy_q),
    .strobe_act (strobe_act),
    .wr_commit  (wr_commit)
);

// File: tb/tb_hbus_slave.sv
`timescale 1ns/1ps
module tb_hbus_slave;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_style;
    logic       addr_muxed;
    logic       latch_in;
    logic       rd_dir_in;
    logic       wr_ds_in;
    logic [5:0] addr_in;
    logic [7:0] data_in;
    logic [7:0] data_out;
    logic       data_oe;
    logic       done_n;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_mem [64];

    always #4 clk = ~clk;

    hbus_slave dut (
        .clk        (clk),
        .rst        (rst),
        .bus_style  (bus_style),
        .addr_muxed (addr_muxed),
        .latch_in   (latch_in),
        .rd_dir_in  (rd_dir_in),
        .wr_ds_in   (wr_ds_in),
        .addr_in    (addr_in),
        .data_in    (data_in),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .done_n     (done_n)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string addr_req();
        if (!bus_style) return addr_muxed ? "R2" : "R3";
        return addr_muxed ? "R5" : "R6";
    endfunction

    task automatic set_mode(input bit st, input bit mx);
        bus_style  = st;
        addr_muxed = mx;
        latch_in   = 1'b1;
        rd_dir_in  = 1'b1;
        wr_ds_in   = 1'b1;
        repeat (3) tick();
    endtask

    task automatic addr_phase(input int a);
        if (addr_muxed) begin
            data_in  = 8'(a);
            addr_in  = ~6'(a);          // R2: dedicated pins carry garbage
            latch_in = 1'b1;
            tick();
            latch_in = 1'b0;
            repeat (3) tick();
        end else begin
            addr_in  = 6'(a);
            data_in  = 8'h5A;
            latch_in = 1'b1;
        end
    endtask

    task automatic bus_cycle(input int a, input bit is_read, input int val,
                             output int rd);
        rd = 0;
        addr_phase(a);
        if (bus_style) begin
            rd_dir_in = is_read;        // R7: direction set before the strobe
            tick();
        end
        data_in = is_read ? 8'hC3 : 8'(val);
        if (!bus_style && is_read) rd_dir_in = 1'b0;
        else                       wr_ds_in  = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            tick();
            if (k == 3) check(done_n == 1'b1, "R9", "done_n before wait end", done_n, 1);
            if (k == 4) check(done_n == 1'b0, "R9", "done_n at wait end", done_n, 0);
        end
        if (is_read) begin
            check(data_oe == 1'b1, "R8", "data_oe during read", data_oe, 1);
            rd = int'(data_out);
        end else begin
            check(data_oe == 1'b0, "R8", "data_oe during write", data_oe, 0);
        end
        rd_dir_in = bus_style ? rd_dir_in : 1'b1;
        wr_ds_in  = 1'b1;
        tick();
        tick();
        check(done_n == 1'b0, "R10", "done_n two clocks after release", done_n, 0);
        tick();
        check(done_n == 1'b1, "R10", "done_n three clocks after release", done_n, 1);
        check(data_oe == 1'b0, "R8", "data_oe after release", data_oe, 0);
    endtask

    task automatic do_write(input int a, input int val);
        int unused;
        bus_cycle(a, 1'b0, val, unused);
        exp_mem[a] = 8'(val);
    endtask

    task automatic do_read(input int a, input string req);
        int got;
        bus_cycle(a, 1'b1, 0, got);
        check(got == int'(exp_mem[a]), req, $sformatf("read addr %0d", a),
              got, int'(exp_mem[a]));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        bus_style  = 1'b0;
        addr_muxed = 1'b0;
        latch_in   = 1'b1;
        rd_dir_in  = 1'b1;
        wr_ds_in   = 1'b1;
        addr_in    = '0;
        data_in    = '0;
        rst        = 1'b1;
        for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1: idle outputs after reset
        check(done_n == 1'b1, "R1", "done_n after reset", done_n, 1);
        check(data_oe == 1'b0, "R1", "data_oe after reset", data_oe, 0);

        // R1: every register is zero
        set_mode(1'b0, 1'b0);
        for (int a = 0; a < 64; a++) do_read(a, "R1");

        // R2 R3 R4 R5 R6 R7: full sweep in every style/address combination
        for (int m = 0; m < 4; m++) begin
            set_mode(m[0], m[1]);
            for (int a = 0; a < 64; a++)
                do_write(a, (a * 37 + m * 11 + 5) & 255);
            for (int a = 0; a < 64; a++)
                do_read(a, addr_req());
        end

        // R7: a read cycle with busy data pins must not modify anything
        set_mode(1'b1, 1'b0);
        do_read(9, "R7");
        set_mode(1'b0, 1'b1);
        do_read(9, "R7");

        // R4: written in one style, read in the other
        set_mode(1'b0, 1'b0);
        do_write(17, 8'hE7);
        set_mode(1'b1, 1'b1);
        do_read(17, "R4");

        // R10: single-clock strobe produces no completion pulse
        set_mode(1'b0, 1'b0);
        addr_in   = 6'd3;
        rd_dir_in = 1'b0;
        tick();
        rd_dir_in = 1'b1;
        begin
            bit saw_low = 1'b0;
            for (int k = 0; k < 8; k++) begin
                tick();
                if (!done_n) saw_low = 1'b1;
            end
            check(!saw_low, "R10", "done_n pulse after short strobe", saw_low, 0);
        end
        do_read(3, "R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule